// File: doc/BRIEF.md
# Memory Decoder Register Bank

This block holds the programming state for a small set of host-managed memory address decoders and presents it on a plain 32-bit register port. Each decoder owns a 64-bit base, a 64-bit size, a control word and a 64-bit target list. Every stored field is filtered by a write mask, so reserved and read-only bits never change. A read-only capability word reports how many decoders exist in encoded form. A global control word carries the poison-on-error enable and the decoder-enable bit.

Software arms a decoder by writing its control word with the commit request bit set. The bank then reports the decoder as committed and its error bit as clear. Writing the request bit as zero withdraws the commit. All decoder fields, together with the committed flags, are driven out continuously for the downstream address logic. A read returns the addressed word in the same cycle. A write takes effect at the next clock edge.

Top module: `memdec_regbank`

## Requirements
- R1: After reset, every decoder word, the global control word and every committed flag read as zero.
- R2: Byte offset 0x00 is the capability word. Bits 3:0 hold the encoded decoder count (1→0, 2→1, 4→2, 6→3, 8→4, 10→5, 12→6, 14→7, 16→8, 20→9, 24→0xA, 28→0xB, 32→0xC), so four decoders read 2. All other bits read 0, and writes to this word are ignored.
- R3: Byte offset 0x04 is the global control word. Only bits 1:0 are writable. Bit 0 drives `poison_en_o` and bit 1 drives `dec_en_o`.
- R4: Decoder n occupies 0x20 bytes starting at 0x10 + 0x20·n. Its words are base low (+0x00), base high (+0x04), size low (+0x08), size high (+0x0C), control (+0x10), target low (+0x14) and target high (+0x18).
- R5: In base low and size low only bits 31:28 are writable and the other bits read 0. Base high and size high are fully writable.
- R6: The control word's writable mask is 0x13FF. Bit 9 is the commit request, and it reads back as it was written.
- R7: A control-word write with bit 9 set makes committed (bit 10) read 1 and error (bit 11) read 0 from the next cycle on. A control-word write with bit 9 clear makes both read 0.
- R8: Values written into bits 10 and 11 of a control word are ignored. Only the commit request bit decides these two bits.
- R9: For an endpoint build (ENDPOINT=1), only bits 31:28 of target low are writable. For a bridge or switch build (ENDPOINT=0), the whole word is writable. Target high is always fully writable.
- R10: Commit handling is per decoder. A control write to one decoder leaves every other decoder's committed flag and words unchanged.
- R11: Writes to unmapped or unaligned offsets change no state, and reads from them return 0. Unmapped offsets are 0x08, 0x0C, word +0x1C of each decoder, and any offset past the last decoder.
- R12: `dec_base_o`, `dec_size_o`, `dec_ctrl_o`, `dec_tgt_o` and `dec_committed_o` present each decoder's current register contents. Decoder n sits in slice n, with the high word in the upper half of each 64-bit slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Write strobe for the word at addr_i |
| addr_i | input | ADDR_W | Byte offset of the accessed word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| dec_base_o | output | 64·NUM_DEC | Base address of each decoder |
| dec_size_o | output | 64·NUM_DEC | Size of each decoder |
| dec_ctrl_o | output | 32·NUM_DEC | Control word of each decoder, including the status bits |
| dec_tgt_o | output | 64·NUM_DEC | Target list of each decoder |
| dec_committed_o | output | NUM_DEC | Committed flag of each decoder |
| poison_en_o | output | 1 | Global poison-on-error enable |
| dec_en_o | output | 1 | Global decoder enable |

## Verification
Every word is written with all ones, and the readback shows which bits the mask keeps, so a wrong mask on any word type is exposed. Sparse patterns such as 0xA5A5A5A5 and 0x3ABCDEF0 separate a masked merge from a plain overwrite. Control writes that set bits 10 and 11 without bit 9, followed by writes that set bit 9 alone, tell a faithful commit handshake apart from one that stores the status bits directly. Writes of zeros and ones to unmapped, unaligned and out-of-range offsets are followed by readback of the neighbouring decoders, which reveals any aliasing. A second build with ENDPOINT=0 tells the two target-low masks apart.

// File: rtl/memdec_pkg.sv
package memdec_pkg;

  localparam int unsigned REG_W = 32;

  // fixed offsets within the bank (bytes)
  localparam int unsigned OFS_CAP   = 'h00;
  localparam int unsigned OFS_GLB   = 'h04;
  localparam int unsigned OFS_SLOT0 = 'h10;
  localparam int unsigned SLOT_SHIFT = 5;   // 0x20 bytes per decoder

  // write masks
  localparam logic [REG_W-1:0] MASK_TOP4 = 32'hF000_0000;
  localparam logic [REG_W-1:0] MASK_ALL  = 32'hFFFF_FFFF;
  localparam logic [REG_W-1:0] MASK_CTRL = 32'h0000_13FF;
  localparam logic [REG_W-1:0] MASK_GLB  = 32'h0000_0003;

  localparam int unsigned CTRL_REQ_BIT  = 9;
  localparam int unsigned CTRL_DONE_BIT = 10;
  localparam int unsigned CTRL_ERR_BIT  = 11;

  typedef enum logic [2:0] {
    W_BASE_LO = 3'd0,
    W_BASE_HI = 3'd1,
    W_SIZE_LO = 3'd2,
    W_SIZE_HI = 3'd3,
    W_CTRL    = 3'd4,
    W_TGT_LO  = 3'd5,
    W_TGT_HI  = 3'd6,
    W_HOLE    = 3'd7
  } slot_word_e;

  // encoded decoder count for the capability word
  function automatic logic [3:0] count_code(int unsigned n);
    case (n)
      1:  return 4'h0;
      2:  return 4'h1;
      4:  return 4'h2;
      6:  return 4'h3;
      8:  return 4'h4;
      10: return 4'h5;
      12: return 4'h6;
      14: return 4'h7;
      16: return 4'h8;
      20: return 4'h9;
      24: return 4'hA;
      28: return 4'hB;
      32: return 4'hC;
      default: return 4'h0;
    endcase
  endfunction

  // keep the bits outside the mask, take the bits inside it from the write
  function automatic logic [REG_W-1:0] masked_merge(logic [REG_W-1:0] old_v,
                                                     logic [REG_W-1:0] new_v,
                                                     logic [REG_W-1:0] mask);
    return (old_v & ~mask) | (new_v & mask);
  endfunction

endpackage

// File: rtl/memdec_addr_dec.sv
module memdec_addr_dec
  import memdec_pkg::*;
#(
  parameter int unsigned NUM_DEC = 4,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic [ADDR_W-1:0]  addr_i,
  output logic               cap_hit_o,
  output logic               glb_hit_o,
  output logic [NUM_DEC-1:0] slot_sel_o,
  output logic [2:0]         word_o
);

  localparam logic [ADDR_W-1:0] SLOT0_A = ADDR_W'(OFS_SLOT0);
  localparam logic [ADDR_W-1:0] NUM_A   = ADDR_W'(NUM_DEC);

  logic [ADDR_W-1:0] off;
  logic [ADDR_W-1:0] slot_idx;
  logic              aligned;
  logic              in_slots;

  always_comb begin
    off      = addr_i - SLOT0_A;
    slot_idx = off >> SLOT_SHIFT;
    aligned  = (addr_i[1:0] == 2'b00);
    in_slots = (addr_i >= SLOT0_A) && (slot_idx < NUM_A) && aligned
               && (off[4:2] != W_HOLE);
    word_o   = off[4:2];
    cap_hit_o = (addr_i == ADDR_W'(OFS_CAP));
    glb_hit_o = (addr_i == ADDR_W'(OFS_GLB));
  end

  for (genvar g = 0; g < NUM_DEC; g++) begin : g_sel
    assign slot_sel_o[g] = in_slots && (slot_idx == ADDR_W'(g));
  end

endmodule

// File: rtl/memdec_slot.sv
module memdec_slot
  import memdec_pkg::*;
#(
  parameter bit ENDPOINT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [2:0]       word_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [63:0]      base_o,
  output logic [63:0]      size_o,
  output logic [31:0]      ctrl_o,
  output logic [63:0]      tgt_o,
  output logic             committed_o,
  output logic [REG_W-1:0] rdata_o
);

  localparam int unsigned NWORDS = 7;
  localparam logic [REG_W-1:0] TGT_LO_MASK = ENDPOINT ? MASK_TOP4 : MASK_ALL;

  function automatic logic [REG_W-1:0] word_mask(logic [2:0] w);
    case (w)
      W_BASE_LO, W_SIZE_LO: return MASK_TOP4;
      W_CTRL:               return MASK_CTRL;
      W_TGT_LO:             return TGT_LO_MASK;
      W_HOLE:               return '0;
      default:              return MASK_ALL;
    endcase
  endfunction

  logic [REG_W-1:0] regs_q [NWORDS];
  logic             done_q;
  logic             ctrl_wr;   // control word write this cycle
  logic [REG_W-1:0] ctrl_view;

  assign ctrl_wr = wr_i && (word_i == W_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NWORDS; k++) regs_q[k] <= '0;
      done_q <= 1'b0;
    end else begin
      for (int k = 0; k < NWORDS; k++) begin
        if (wr_i && (word_i == 3'(k)))
          regs_q[k] <= masked_merge(regs_q[k], wdata_i, word_mask(3'(k)));
      end
      if (ctrl_wr) done_q <= wdata_i[CTRL_REQ_BIT];
    end
  end

  // error bit has no setting source inside the bank and reads 0
  always_comb begin
    ctrl_view = regs_q[W_CTRL];
    ctrl_view[CTRL_DONE_BIT] = done_q;
    ctrl_view[CTRL_ERR_BIT]  = 1'b0;
  end

  assign base_o      = {regs_q[W_BASE_HI], regs_q[W_BASE_LO]};
  assign size_o      = {regs_q[W_SIZE_HI], regs_q[W_SIZE_LO]};
  assign tgt_o       = {regs_q[W_TGT_HI],  regs_q[W_TGT_LO]};
  assign ctrl_o      = ctrl_view;
  assign committed_o = done_q;

  always_comb begin
    case (word_i)
      W_CTRL:  rdata_o = ctrl_view;
      W_HOLE:  rdata_o = '0;
      default: rdata_o = regs_q[word_i];
    endcase
  end

  assert_commit_follows_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (committed_o == $past(wdata_i[CTRL_REQ_BIT])) && !ctrl_o[CTRL_ERR_BIT]);

  assert_status_untouched_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(committed_o));

  assert_low_words_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && (word_i == W_BASE_LO)) |=> (base_o[27:0] == 28'd0));

endmodule

// File: rtl/memdec_regbank.sv
module memdec_regbank
  import memdec_pkg::*;
#(
  parameter int unsigned NUM_DEC  = 4,
  parameter int unsigned ADDR_W   = 8,
  parameter bit          ENDPOINT = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [31:0]            wdata_i,
  output logic [31:0]            rdata_o,
  output logic [NUM_DEC*64-1:0]  dec_base_o,
  output logic [NUM_DEC*64-1:0]  dec_size_o,
  output logic [NUM_DEC*32-1:0]  dec_ctrl_o,
  output logic [NUM_DEC*64-1:0]  dec_tgt_o,
  output logic [NUM_DEC-1:0]     dec_committed_o,
  output logic                   poison_en_o,
  output logic                   dec_en_o
);

  localparam logic [3:0] CNT_CODE = count_code(NUM_DEC);

  logic               cap_hit;
  logic               glb_hit;
  logic [NUM_DEC-1:0] slot_sel;
  logic [NUM_DEC-1:0] slot_wr;
  logic [2:0]         word;
  logic               any_hit;
  logic [1:0]         glb_q;
  logic [31:0]        slot_rd [NUM_DEC];

  memdec_addr_dec #(.NUM_DEC(NUM_DEC), .ADDR_W(ADDR_W)) u_dec (
    .addr_i     (addr_i),
    .cap_hit_o  (cap_hit),
    .glb_hit_o  (glb_hit),
    .slot_sel_o (slot_sel),
    .word_o     (word)
  );

  assign slot_wr = slot_sel & {NUM_DEC{wr_en_i}};
  assign any_hit = cap_hit || glb_hit || (|slot_sel);

  for (genvar g = 0; g < NUM_DEC; g++) begin : g_slot
    memdec_slot #(.ENDPOINT(ENDPOINT)) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_i        (slot_wr[g]),
      .word_i      (word),
      .wdata_i     (wdata_i),
      .base_o      (dec_base_o[g*64 +: 64]),
      .size_o      (dec_size_o[g*64 +: 64]),
      .ctrl_o      (dec_ctrl_o[g*32 +: 32]),
      .tgt_o       (dec_tgt_o[g*64 +: 64]),
      .committed_o (dec_committed_o[g]),
      .rdata_o     (slot_rd[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) glb_q <= 2'b00;
    else if (wr_en_i && glb_hit) glb_q <= wdata_i[1:0] & MASK_GLB[1:0];
  end

  assign poison_en_o = glb_q[0];
  assign dec_en_o    = glb_q[1];

  always_comb begin
    rdata_o = '0;
    if (cap_hit) rdata_o = {28'd0, CNT_CODE};
    if (glb_hit) rdata_o = {30'd0, glb_q};
    for (int k = 0; k < NUM_DEC; k++)
      if (slot_sel[k]) rdata_o = rdata_o | slot_rd[k];
  end

  assert_one_slot_written_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_wr));

  assert_unmapped_reads_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !any_hit |-> (rdata_o == 32'd0));

  assert_unmapped_write_dropped_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !any_hit) |=> ($stable(dec_ctrl_o) && $stable(dec_base_o) && $stable(dec_tgt_o)));

  assert_cap_readonly_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hit |-> (rdata_o[31:4] == 28'd0));

endmodule

// File: tb/test_memdec_regbank.sv
module test_memdec_regbank;

  localparam int CLK_NS = 10;
  localparam int NV = 15;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_sw;
  logic [255:0] base, size, tgt, base_sw, size_sw, tgt_sw;
  logic [127:0] ctrl, ctrl_sw;
  logic [3:0]  committed, committed_sw;
  logic        poison_en, dec_en, poison_sw, dec_en_sw;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  memdec_regbank i_memdec_regbank (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .dec_base_o(base), .dec_size_o(size), .dec_ctrl_o(ctrl),
    .dec_tgt_o(tgt), .dec_committed_o(committed), .poison_en_o(poison_en),
    .dec_en_o(dec_en)
  );

  // bridge/switch build for the target-low mask (R9)
  memdec_regbank #(.ENDPOINT(1'b0)) i_memdec_regbank_sw (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata_sw), .dec_base_o(base_sw), .dec_size_o(size_sw), .dec_ctrl_o(ctrl_sw),
    .dec_tgt_o(tgt_sw), .dec_committed_o(committed_sw), .poison_en_o(poison_sw),
    .dec_en_o(dec_en_sw)
  );

  // write-then-read vectors for the endpoint build
  localparam logic [7:0]  VA [NV] = '{8'h10, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h24, 8'h28,
                                      8'h70, 8'h80, 8'h04, 8'h00, 8'h08, 8'h2C, 8'h90, 8'h11};
  localparam logic [31:0] VD [NV] = '{32'hFFFF_FFFF, 32'h1234_5678, 32'h3ABC_DEF0, 32'hFFFF_FFFF,
                                      32'hFFFF_FFFF, 32'hA5A5_A5A5, 32'h0102_0304, 32'h5FFF_FFFF,
                                      32'h0000_0C11, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
                                      32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000};
  localparam logic [31:0] VE [NV] = '{32'hF000_0000, 32'h1234_5678, 32'h3000_0000, 32'hFFFF_FFFF,
                                      32'h0000_17FF, 32'hA000_0000, 32'h0102_0304, 32'h5000_0000,
                                      32'h0000_0011, 32'h0000_0003, 32'h0000_0002, 32'h0000_0000,
                                      32'h0000_0000, 32'h0000_0000, 32'h0000_0000};
  // R5 R5 R5 R5 R6 R9 R4 R4 R8 R3 R2 R11 R11 R11 R11
  localparam int          VR [NV] = '{5, 5, 5, 5, 6, 9, 4, 4, 8, 3, 2, 11, 11, 11, 11};

  task automatic check(int req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a);
    addr = a;
    #1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(8'h10); check(1, rdata, 32'h0);
    rd(8'h14); check(1, rdata, 32'h0);
    rd(8'h20); check(1, rdata, 32'h0);
    rd(8'h24); check(1, rdata, 32'h0);
    rd(8'h80); check(1, rdata, 32'h0);
    rd(8'h04); check(1, rdata, 32'h0);
    check(1, {28'd0, committed}, 32'h0);
    rd(8'h00); check(2, rdata, 32'h2);

    for (int i = 0; i < NV; i++) begin
      wr(VA[i], VD[i]);
      rd(VA[i]);
      check(VR[i], rdata, VE[i]);
    end

    // R7/R12 export after commit on decoder 0
    check(7, {31'd0, committed[0]}, 32'h1);
    check(12, base[63:32], 32'h1234_5678);
    check(12, base[31:0], 32'hF000_0000);
    check(12, size[31:0], 32'h3000_0000);
    check(12, tgt[31:0], 32'hA000_0000);
    check(3, {30'd0, dec_en, poison_en}, 32'h3);
    // R11 no aliasing of dropped writes
    rd(8'h10); check(11, rdata, 32'hF000_0000);
    rd(8'h30); check(11, rdata, 32'h0);
    rd(8'h90); check(11, rdata, 32'h0);
    // R9 bridge build keeps the full target low word
    rd(8'h24); check(9, rdata_sw, 32'hA5A5_A5A5);
    // R7 uncommit
    wr(8'h20, 32'h0);
    rd(8'h20); check(7, rdata, 32'h0);
    check(7, {31'd0, committed[0]}, 32'h0);
    // R7/R8 commit with status bits also written
    wr(8'h20, 32'h0000_0A00);
    rd(8'h20); check(8, rdata, 32'h0000_0600);
    // R10 independent decoders
    wr(8'h60, 32'h0000_0200);
    check(10, {28'd0, committed}, 32'h5);
    rd(8'h40); check(10, rdata, 32'h0);
    rd(8'h80); check(10, rdata, 32'h0000_0011);
    // R2 capability ignores writes
    wr(8'h00, 32'h0);
    rd(8'h00); check(2, rdata, 32'h2);

    finish_run();
  end

endmodule